// File: doc/BRIEF.md
# Page Read-Back Verify With Per-Sector Flip Tolerance

This block judges whether a freshly programmed flash page reads back well enough. The read byte and the expected pattern byte come in together on every valid cycle. The block counts the bits that differ between them and adds that number to a counter for the current sector. When a sector closes, its count is compared with a configured tolerance. The tolerance matches the number of bits the target's error-correcting code can repair in one sector. A handful of flips on a fresh part is therefore accepted, while a sector whose count is above the tolerance fails the page. Setting the tolerance to zero makes the check strict: every flipped bit fails the page.

Sectors are measured by counting main-area bytes from the page's first byte, using a programmable sector length. A page that ends part-way through a sector closes that partial sector. Bytes marked as spare area must match exactly by default. A configuration bit can instead add the spare flips to the count of the last closed sector and judge the sum against the tolerance. A failed page sets a sticky reject flag, which stays set until it is explicitly cleared. The largest sector count seen is held as a status value.

Top module: `flipTolVerify`

## Requirements
- R1: For each byte accepted while `inValid` is high, the mismatch count is the number of 1 bits in `rdByte XOR expByte`. A sector's count is the sum of these counts over its bytes. When the sector closes, `sectorDone` pulses for one cycle and `sectorErrs` holds the count, in the cycle after the sector's last byte.
- R2: A sector closes on its `cfgSectorBytes`-th main-area byte, counting from the byte that carries `pageFirst`. The next sector's count starts from zero, so each sector is counted independently.
- R3: A sector count saturates at 127 and never wraps.
- R4: `pageDone` pulses for one cycle after the byte that carries `pageLast`. `pagePass` is 0 if any sector of that page has a count strictly greater than `cfgTolBits`. A count equal to the tolerance passes.
- R5: With `cfgTolBits` = 0, a single flipped bit in the main area fails the page, and an exact page passes.
- R6: With `cfgSpareInTol` = 0, any mismatch in a byte at or after `spareFirst` fails the page, whatever the tolerance.
- R7: With `cfgSpareInTol` = 1, the spare-area flips are added to the last closed sector's count. The page fails if that sum is greater than `cfgTolBits`.
- R8: `deviceReject` goes to 1 after any failed page. It stays at 1 until `rejectClr` is sampled high. A failure in the same cycle as the clear keeps it at 1.
- R9: `worstErrs` holds the largest sector count closed since reset or since the last `rejectClr`. `rejectClr` sets it to 0.
- R10: Cycles with `inValid` low change no count, marker or result, whatever the data and marker inputs carry.
- R11: After reset, `sectorDone`, `sectorErrs`, `pageDone`, `pagePass`, `deviceReject` and `worstErrs` are all 0.
- R12: A `pageLast` on a main-area byte closes the sector in progress, even if it is shorter than `cfgSectorBytes`, and that sector is judged like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSectorBytes | input | 12 | Sector length in bytes (512 to 2048) |
| cfgTolBits | input | 6 | Flipped bits allowed per sector (0 to 63) |
| cfgSpareInTol | input | 1 | 1: spare flips join the last sector's tolerance; 0: the spare area must match exactly |
| inValid | input | 1 | Byte pair valid this cycle |
| rdByte | input | 8 | Byte read back from the device |
| expByte | input | 8 | Expected pattern byte |
| pageFirst | input | 1 | This byte is the first of a page |
| spareFirst | input | 1 | This byte is the first spare-area byte |
| pageLast | input | 1 | This byte is the last of the page |
| rejectClr | input | 1 | Clears the reject flag and the worst count |
| sectorDone | output | 1 | One-cycle pulse when a sector closes |
| sectorErrs | output | 7 | Count of the sector that just closed |
| pageDone | output | 1 | One-cycle pulse when a page ends |
| pagePass | output | 1 | Verdict of the page that just ended |
| deviceReject | output | 1 | Sticky reject flag |
| worstErrs | output | 7 | Largest sector count seen |

## Verification
Every result is registered on the rising edge that takes the closing byte, so all results appear one cycle after that byte. This covers `sectorDone`/`sectorErrs`, `pageDone`/`pagePass`, the reject flag and the worst count. The bench drives each byte on the falling edge and samples the outputs 1 ns after the following rising edge. Since the done pulses last exactly one cycle, this sampling point catches each pulse once, before the next byte can clear it. Idle cycles with garbage data are sampled the same way, to confirm that no pulse appears.

// File: rtl/flipTolPkg.sv
package flipTolPkg;
  // strobes from the sequencing control to the counting datapath
  typedef struct packed {
    logic valid;
    logic secFirst;
    logic secClose;
    logic inSpare;
    logic spareFirst;
    logic pageFirst;
    logic pageClose;
  } tolStrb_t;
endpackage

// File: rtl/flipTolCtl.sv
module flipTolCtl
  import flipTolPkg::*;
#(
  parameter int IDXW = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [IDXW-1:0] cfgSectorBytes,
  input  logic            inValid,
  input  logic            pageFirst,
  input  logic            spareFirst,
  input  logic            pageLast,
  output tolStrb_t        strb
);
  logic [IDXW-1:0] byteIdx;
  logic [IDXW-1:0] curIdx;
  logic            spareReg;
  logic            inSpareNow;
  logic            atSecEnd;

  always_comb begin
    curIdx     = pageFirst ? '0 : byteIdx;
    inSpareNow = spareFirst | (spareReg & ~pageFirst);
    atSecEnd   = (curIdx == cfgSectorBytes - IDXW'(1));
    strb.valid      = inValid;
    strb.secFirst   = inValid & ~inSpareNow & (curIdx == '0);
    strb.secClose   = inValid & ~inSpareNow & (atSecEnd | pageLast);
    strb.inSpare    = inValid & inSpareNow;
    strb.spareFirst = inValid & spareFirst;
    strb.pageFirst  = inValid & pageFirst;
    strb.pageClose  = inValid & pageLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx  <= '0;
      spareReg <= 1'b0;
    end else if (inValid) begin
      if (!inSpareNow) byteIdx <= strb.secClose ? '0 : curIdx + IDXW'(1);
      spareReg <= pageLast ? 1'b0 : inSpareNow;
    end
  end

  // r12: a page end inside the main area must close the open sector
  a_r12_tail_close: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && pageLast && !spareFirst && !spareReg) |-> strb.secClose);
endmodule

// File: rtl/flipTolDp.sv
module flipTolDp
  import flipTolPkg::*;
#(
  parameter int DW   = 8,
  parameter int TOLW = 6,
  localparam int ERRW = TOLW + 1,
  localparam int PCW  = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  tolStrb_t        strb,
  input  logic [DW-1:0]   rdByte,
  input  logic [DW-1:0]   expByte,
  input  logic [TOLW-1:0] cfgTolBits,
  input  logic            cfgSpareInTol,
  input  logic            rejectClr,
  output logic            sectorDone,
  output logic [ERRW-1:0] sectorErrs,
  output logic            pageDone,
  output logic            pagePass,
  output logic            deviceReject,
  output logic [ERRW-1:0] worstErrs
);
  localparam logic [ERRW-1:0] ERR_MAX = '1;

  function automatic logic [ERRW-1:0] satAdd(input logic [ERRW-1:0] a, input logic [ERRW-1:0] b);
    logic [ERRW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ERRW] ? ERR_MAX : s[ERRW-1:0];
  endfunction

  logic [PCW-1:0]  flipCnt;
  logic [ERRW-1:0] acc, accNew, spAcc, spNew, spTot, lastSec, lastNow;
  logic            pageFail, secFail, spareFail, failNow;
  logic [ERRW-1:0] tolExt;

  always_comb begin
    flipCnt = '0;
    for (int b = 0; b < DW; b++) flipCnt = flipCnt + PCW'(rdByte[b] ^ expByte[b]);
    tolExt    = {1'b0, cfgTolBits};
    accNew    = satAdd(strb.secFirst ? '0 : acc, ERRW'(flipCnt));
    spNew     = satAdd(strb.spareFirst ? '0 : spAcc, ERRW'(flipCnt));
    spTot     = strb.inSpare ? spNew : spAcc;
    lastNow   = strb.secClose ? accNew : lastSec;
    secFail   = strb.secClose && (accNew > tolExt);
    spareFail = cfgSpareInTol ? (satAdd(lastNow, spTot) > tolExt) : (spTot != '0);
    failNow   = (strb.pageFirst ? 1'b0 : pageFail) | secFail | (strb.pageClose & spareFail);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0; spAcc <= '0; lastSec <= '0; pageFail <= 1'b0;
      sectorDone <= 1'b0; sectorErrs <= '0; pageDone <= 1'b0; pagePass <= 1'b0;
      deviceReject <= 1'b0; worstErrs <= '0;
    end else begin
      sectorDone <= strb.secClose;
      pageDone   <= strb.pageClose;
      if (strb.valid) begin
        pageFail <= failNow;
        if (!strb.inSpare) acc <= accNew;
        if (strb.inSpare) spAcc <= spNew;
        else if (strb.pageFirst) spAcc <= '0;
      end
      if (strb.secClose) begin
        sectorErrs <= accNew;
        lastSec    <= accNew;
      end
      if (strb.pageClose) pagePass <= ~failNow;
      if (rejectClr) worstErrs <= strb.secClose ? accNew : '0;
      else if (strb.secClose && accNew > worstErrs) worstErrs <= accNew;
      if (strb.pageClose && failNow) deviceReject <= 1'b1;
      else if (rejectClr) deviceReject <= 1'b0;
    end
  end

  // r8: reject flag only drops on an explicit clear
  a_r8_reject_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (deviceReject && !rejectClr) |=> deviceReject);
  // r8: a reported failing page always leaves the flag raised
  a_r8_fail_rejects: assert property (@(posedge clk) disable iff (!rstN)
    (pageDone && !pagePass) |-> deviceReject);
  // r9: the worst count covers every reported sector
  a_r9_worst_cover: assert property (@(posedge clk) disable iff (!rstN)
    sectorDone |-> (worstErrs >= sectorErrs));
  // r10: idle cycles leave status untouched
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.valid && !rejectClr) |=> ($stable(worstErrs) && $stable(deviceReject) && !sectorDone && !pageDone));
endmodule

// File: rtl/flipTolVerify.sv
module flipTolVerify
  import flipTolPkg::*;
#(
  parameter int IDXW = 12,
  parameter int TOLW = 6,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [IDXW-1:0] cfgSectorBytes,
  input  logic [TOLW-1:0] cfgTolBits,
  input  logic            cfgSpareInTol,
  input  logic            inValid,
  input  logic [DW-1:0]   rdByte,
  input  logic [DW-1:0]   expByte,
  input  logic            pageFirst,
  input  logic            spareFirst,
  input  logic            pageLast,
  input  logic            rejectClr,
  output logic            sectorDone,
  output logic [TOLW:0]   sectorErrs,
  output logic            pageDone,
  output logic            pagePass,
  output logic            deviceReject,
  output logic [TOLW:0]   worstErrs
);
  tolStrb_t strb;

  flipTolCtl #(.IDXW(IDXW)) uCtl (
    .clk(clk), .rstN(rstN), .cfgSectorBytes(cfgSectorBytes), .inValid(inValid),
    .pageFirst(pageFirst), .spareFirst(spareFirst), .pageLast(pageLast), .strb(strb)
  );

  flipTolDp #(.DW(DW), .TOLW(TOLW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdByte(rdByte), .expByte(expByte),
    .cfgTolBits(cfgTolBits), .cfgSpareInTol(cfgSpareInTol), .rejectClr(rejectClr),
    .sectorDone(sectorDone), .sectorErrs(sectorErrs), .pageDone(pageDone),
    .pagePass(pagePass), .deviceReject(deviceReject), .worstErrs(worstErrs)
  );
endmodule

// File: tb/sim_flipTolVerify.sv
`timescale 1ns/1ps
module sim_flipTolVerify;
  logic clk = 1'b0, rstN = 1'b0;
  logic [11:0] cfgSectorBytes = 12'd512;
  logic [5:0]  cfgTolBits = 6'd4;
  logic cfgSpareInTol = 1'b0, inValid = 1'b0;
  logic [7:0] rdByte = '0, expByte = '0;
  logic pageFirst = 0, spareFirst = 0, pageLast = 0, rejectClr = 0;
  logic sectorDone, pageDone, pagePass, deviceReject;
  logic [6:0] sectorErrs, worstErrs;

  int total = 0, bad = 0;
  int got[8];
  int nGot, gotPass, gotDone, idleHits;

  always #4 clk = ~clk;

  flipTolVerify u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int flipsAt(input int tot, input int pos);
    int k = tot - pos * 8;
    if (k < 0) k = 0;
    if (k > 8) k = 8;
    return k;
  endfunction

  // drives one page; sector flip totals f0..f2, spare flip total sf
  task automatic runPage(input int mainLen, input int spareN, input int f0, input int f1,
                         input int f2, input int sf, input bit gaps);
    int secB = int'(cfgSectorBytes);
    int len = mainLen + spareN;
    nGot = 0; gotPass = -1; gotDone = 0; idleHits = 0;
    for (int i = 0; i < len; i++) begin
      int k;
      logic [7:0] e;
      e = 8'((i * 37 + 5) & 255);
      if (i < mainLen) begin
        int s = i / secB;
        k = flipsAt(s == 0 ? f0 : s == 1 ? f1 : s == 2 ? f2 : 0, i % secB);
      end else k = flipsAt(sf, i - mainLen);
      @(negedge clk);
      inValid = 1; expByte = e;
      rdByte = e ^ ((k == 8) ? 8'hFF : 8'((1 << k) - 1));
      pageFirst = (i == 0); spareFirst = (spareN > 0 && i == mainLen); pageLast = (i == len - 1);
      @(posedge clk); #1;
      if (sectorDone) begin got[nGot] = int'(sectorErrs); nGot++; end
      if (pageDone) begin gotDone = 1; gotPass = int'(pagePass); end
      if (gaps && (i % 7 == 3) && i != len - 1) begin
        @(negedge clk);
        inValid = 0; rdByte = ~e; pageFirst = 1; spareFirst = 1; pageLast = 1;
        @(posedge clk); #1;
        if (sectorDone || pageDone) idleHits++;
      end
    end
    @(negedge clk);
    inValid = 0; pageFirst = 0; spareFirst = 0; pageLast = 0;
  endtask

  task automatic pulseClear();
    @(negedge clk); rejectClr = 1;
    @(posedge clk); #1;
    @(negedge clk); rejectClr = 0;
  endtask

  task automatic testReset();
    check(sectorDone == 0 && pageDone == 0 && pagePass == 0, "R11 pulses/verdict at reset", int'(sectorDone | pageDone | pagePass), 0);
    check(deviceReject == 0 && sectorErrs == 0 && worstErrs == 0, "R11 flags/counts at reset", int'(deviceReject) + int'(sectorErrs) + int'(worstErrs), 0);
  endtask

  task automatic testCleanPage();
    cfgTolBits = 4; runPage(1024, 16, 0, 0, 0, 0, 0);
    check(nGot == 2 && got[0] == 0 && got[1] == 0, "R1 clean sectors", nGot, 2);
    check(gotDone == 1 && gotPass == 1, "R4 clean page passes", gotPass, 1);
  endtask

  task automatic testAtLimit();
    cfgTolBits = 4; runPage(1024, 16, 3, 4, 0, 0, 0);
    check(got[0] == 3, "R1 sector0 count", got[0], 3);
    check(got[1] == 4, "R1 sector1 count", got[1], 4);
    check(gotPass == 1, "R4 count equal to tolerance passes", gotPass, 1);
    check(deviceReject == 0, "R8 no reject on pass", int'(deviceReject), 0);
  endtask

  task automatic testOverLimit();
    cfgTolBits = 4; runPage(1024, 16, 0, 5, 0, 0, 0);
    check(got[1] == 5, "R1 sector1 count", got[1], 5);
    check(gotPass == 0, "R4 over tolerance fails", gotPass, 0);
    check(deviceReject == 1, "R8 reject set", int'(deviceReject), 1);
    check(int'(worstErrs) == 5, "R9 worst after fail", int'(worstErrs), 5);
  endtask

  task automatic testSticky();
    runPage(1024, 16, 1, 0, 0, 0, 0);
    check(gotPass == 1 && deviceReject == 1, "R8 reject stays after good page", int'(deviceReject), 1);
    pulseClear();
    check(deviceReject == 0, "R8 reject cleared", int'(deviceReject), 0);
    check(worstErrs == 0, "R9 worst cleared", int'(worstErrs), 0);
  endtask

  task automatic testStrict();
    cfgTolBits = 0; runPage(1024, 16, 0, 1, 0, 0, 0);
    check(gotPass == 0, "R5 one flip fails with zero tolerance", gotPass, 0);
    runPage(1024, 16, 0, 0, 0, 0, 0);
    check(gotPass == 1, "R5 exact page passes with zero tolerance", gotPass, 1);
    pulseClear();
  endtask

  task automatic testSpareExact();
    cfgTolBits = 10; cfgSpareInTol = 0;
    runPage(1024, 16, 0, 0, 0, 1, 0);
    check(gotPass == 0, "R6 spare flip fails in exact mode", gotPass, 0);
    check(nGot == 2, "R6 spare opens no sector", nGot, 2);
    pulseClear();
  endtask

  task automatic testSpareInclude();
    cfgSpareInTol = 1; cfgTolBits = 5;
    runPage(1024, 16, 0, 3, 0, 2, 0);
    check(gotPass == 1, "R7 last sector plus spare within tolerance", gotPass, 1);
    cfgTolBits = 4;
    runPage(1024, 16, 0, 3, 0, 2, 0);
    check(gotPass == 0, "R7 last sector plus spare over tolerance", gotPass, 0);
    cfgSpareInTol = 0; pulseClear();
  endtask

  task automatic testSaturate();
    cfgTolBits = 63; runPage(512, 0, 160, 0, 0, 0, 0);
    check(got[0] == 127, "R3 count saturates", got[0], 127);
    check(int'(worstErrs) == 127, "R9 worst holds max", int'(worstErrs), 127);
    check(gotPass == 0, "R4 saturated sector fails", gotPass, 0);
    pulseClear();
  endtask

  task automatic testSectorSize();
    cfgSectorBytes = 1024; cfgTolBits = 8;
    runPage(2048, 0, 7, 2, 0, 0, 0);
    check(nGot == 2, "R2 sector count follows length", nGot, 2);
    check(got[0] == 7 && got[1] == 2, "R2 independent counts", got[0] * 10 + got[1], 72);
    cfgSectorBytes = 512;
  endtask

  task automatic testIdleGaps();
    cfgTolBits = 1; runPage(512, 8, 1, 0, 0, 0, 1);
    check(idleHits == 0, "R10 no pulse on idle cycles", idleHits, 0);
    check(nGot == 1 && got[0] == 1, "R10 idle garbage not counted", got[0], 1);
    check(gotPass == 1, "R10 page verdict unaffected", gotPass, 1);
  endtask

  task automatic testPartial();
    cfgTolBits = 5; runPage(600, 0, 2, 6, 0, 0, 0);
    check(nGot == 2, "R12 partial sector closed", nGot, 2);
    check(got[1] == 6, "R12 partial sector count", got[1], 6);
    check(gotPass == 0, "R12 partial sector judged", gotPass, 0);
    pulseClear();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    testReset();
    testCleanPage();
    testAtLimit();
    testOverLimit();
    testSticky();
    testStrict();
    testSpareExact();
    testSpareInclude();
    testSaturate();
    testSectorSize();
    testIdleGaps();
    testPartial();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule